// File: doc/BRIEF.md
# Frame Delay Timer

This block times the gap between the end of a received frame and the start of the reply. It stays idle until the demodulated receive line falls, or until software asks for a start. Either event clears the count and starts it. From then on, the count moves up by one on each rising edge of the recovered carrier.

When the count reaches the programmed delay value, the transmit-start output goes high. This tells the serial transmitter to begin. A second compare value marks the expected end of the frame and sets only a status flag. A fixed terminal value ends the run: the output drops, counting stops and the count holds. The count does not wrap.

Both the carrier and the receive line are asynchronous to the system clock. Each passes through a synchronizer chain, and the block detects their edges in the system clock domain. Three sticky flags record the delay, frame-end and terminal matches. Software clears each one with a per-flag clear pulse.

Top module: `fdt_timer`

## Requirements
- R1: After reset, `count` is zero and `running`, `tx_start` and all of `match_flags` are low.
- R2: While `running` is low, carrier edges leave `count` and `tx_start` unchanged.
- R3: A falling edge on `rx_data_in` sets `count` to zero, sets `running` and drives `tx_start` low. A rising edge on `rx_data_in` has no effect.
- R4: While running, each rising edge of `carrier_in` raises `count` by exactly one. System clock cycles without a carrier edge leave `count` unchanged.
- R5: When an advance brings `count` equal to `delay_val`, `tx_start` goes high and `match_flags[0]` is set.
- R6: When an advance brings `count` equal to `STOP_VAL` (default all ones), `tx_start` goes low, `running` drops and `match_flags[2]` is set. Later carrier edges leave `count` at `STOP_VAL`.
- R7: When an advance brings `count` equal to `frame_end_val`, the only change is that `match_flags[1]` is set. `tx_start` and `running` do not change.
- R8: The flags in `match_flags` are sticky. A one in bit i of `flag_clr` clears flag i, and a match in the same cycle wins over the clear.
- R9: If the delay match and the terminal match happen on the same advance, the clear wins and `tx_start` stays low.
- R10: A one-cycle pulse on `sw_start` acts exactly like the receive-line trigger, also while already running: `count` goes to zero, `tx_start` goes low and counting continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_in | input | 1 | Recovered carrier, asynchronous |
| rx_data_in | input | 1 | Demodulated receive data, asynchronous, idle high |
| sw_start | input | 1 | Software trigger pulse, synchronous |
| delay_val | input | CNT_W | Count at which transmission starts |
| frame_end_val | input | CNT_W | Count that marks the end of a frame |
| flag_clr | input | 3 | Per-flag clear: bit 0 delay, bit 1 frame end, bit 2 terminal |
| count | output | CNT_W | Current count |
| running | output | 1 | High while the counter advances on carrier edges |
| tx_start | output | 1 | Transmit-start signal |
| match_flags | output | 3 | Sticky flags: bit 0 delay, bit 1 frame end, bit 2 terminal |

## Verification
A wrong count is visible on `count` right after the carrier edge that caused it. That is the third system clock edge after the carrier pin rises. A lost or doubled tick therefore shows up at the next sample. A bad run state shows in one of two ways: `count` moves while `running` is low, or `count` freezes before it reaches the terminal value. A compare that fires at the wrong value shows up when `tx_start` or a flag rises at a count other than the programmed one. The bench compares every output to a tick-by-tick model after each burst of carrier edges.

// File: rtl/fdt_timer.sv
module fdt_timer #(
  parameter int CNT_W = 16,
  parameter int SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] STOP_VAL = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             carrier_in,
  input  logic             rx_data_in,
  input  logic             sw_start,
  input  logic [CNT_W-1:0] delay_val,
  input  logic [CNT_W-1:0] frame_end_val,
  input  logic [2:0]       flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             running,
  output logic             tx_start,
  output logic [2:0]       match_flags
);

  // [SYNC_STAGES-1] is the synchronized level, [SYNC_STAGES] its previous value
  logic [SYNC_STAGES:0] car_sh, dat_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      car_sh <= '0;
      dat_sh <= '1;
    end else begin
      car_sh <= {car_sh[SYNC_STAGES-1:0], carrier_in};
      dat_sh <= {dat_sh[SYNC_STAGES-1:0], rx_data_in};
    end
  end

  wire tick = car_sh[SYNC_STAGES-1] & ~car_sh[SYNC_STAGES];
  wire fall = dat_sh[SYNC_STAGES] & ~dat_sh[SYNC_STAGES-1];
  wire trig = fall | sw_start;
  wire adv  = running & tick & ~trig;

  wire [CNT_W-1:0] cnt_nxt = count + 1'b1;
  wire hit_dly  = adv & (cnt_nxt == delay_val);
  wire hit_fend = adv & (cnt_nxt == frame_end_val);
  wire hit_stop = adv & (cnt_nxt == STOP_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count    <= '0;
      running  <= 1'b0;
      tx_start <= 1'b0;
    end else if (trig) begin
      count    <= '0;
      running  <= 1'b1;
      tx_start <= 1'b0;
    end else if (adv) begin
      count <= cnt_nxt;
      if (hit_stop) begin
        running  <= 1'b0;
        tx_start <= 1'b0;
      end else if (hit_dly) begin
        tx_start <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) match_flags <= '0;
    else        match_flags <= (match_flags & ~flag_clr) | {hit_stop, hit_fend, hit_dly};
  end

endmodule

// File: rtl/fdt_timer_chk.sv
module fdt_timer_chk #(
  parameter int CNT_W = 16,
  parameter logic [CNT_W-1:0] STOP_VAL = {CNT_W{1'b1}}
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             running,
  input logic             tx_start,
  input logic [CNT_W-1:0] delay_val,
  input logic [2:0]       match_flags
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> (count == $past(count)) || (count == '0));

  assert_single_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> (count == $past(count)) || (count == $past(count) + 1'b1) || (count == '0));

  assert_tx_at_delay_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_start) |-> (count == delay_val));

  assert_halt_at_stop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (count == STOP_VAL) |-> (!running && !tx_start));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= STOP_VAL);

  assert_stop_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flags[2]) |-> (count == STOP_VAL));

endmodule

bind fdt_timer fdt_timer_chk #(.CNT_W(CNT_W), .STOP_VAL(STOP_VAL)) u_chk (
  .clk(clk), .rst_n(rst_n), .count(count), .running(running),
  .tx_start(tx_start), .delay_val(delay_val), .match_flags(match_flags)
);

// File: tb/tb_fdt_timer.sv
`timescale 1ns/1ps
module tb_fdt_timer;
  localparam int W = 8;
  localparam logic [W-1:0] STOP = {W{1'b1}};

  logic clk = 1'b0, rst_n = 1'b0;
  logic carrier_in = 1'b0, rx_data_in = 1'b1, sw_start = 1'b0;
  logic [W-1:0] delay_val = '0, frame_end_val = '0;
  logic [2:0] flag_clr = '0;
  logic [W-1:0] count;
  logic running, tx_start;
  logic [2:0] match_flags;

  fdt_timer #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .carrier_in(carrier_in), .rx_data_in(rx_data_in),
    .sw_start(sw_start), .delay_val(delay_val), .frame_end_val(frame_end_val),
    .flag_clr(flag_clr), .count(count), .running(running), .tx_start(tx_start),
    .match_flags(match_flags)
  );

  always #2.5 clk = ~clk;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;
  logic [W-1:0] m_cnt;
  logic m_run, m_tx;
  logic [2:0] m_fl;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " count"}, 32'(count), 32'(m_cnt));
    chk({req, " running"}, 32'(running), 32'(m_run));
    chk({req, " tx_start"}, 32'(tx_start), 32'(m_tx));
    chk({req, " flags"}, 32'(match_flags), 32'(m_fl));
  endtask

  function automatic void model_tick();
    if (m_run) begin
      m_cnt = m_cnt + 1'b1;
      if (m_cnt == frame_end_val) m_fl[1] = 1'b1;
      if (m_cnt == delay_val) m_fl[0] = 1'b1;
      if (m_cnt == STOP) begin m_run = 1'b0; m_tx = 1'b0; m_fl[2] = 1'b1; end
      else if (m_cnt == delay_val) m_tx = 1'b1;
    end
  endfunction

  function automatic void model_trig();
    m_cnt = '0; m_run = 1'b1; m_tx = 1'b0;
  endfunction

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) carrier_in = 1'b1;
      repeat (3) @(negedge clk);
      carrier_in = 1'b0;
      repeat (3) @(negedge clk);
      model_tick();
    end
  endtask

  task automatic data_fall();
    @(negedge clk) rx_data_in = 1'b0;
    repeat (4) @(negedge clk);
    model_trig();
    rx_data_in = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic soft_start();
    @(negedge clk) sw_start = 1'b1;
    @(negedge clk) sw_start = 1'b0;
    model_trig();
  endtask

  task automatic clear_flags(input logic [2:0] m);
    @(negedge clk) flag_clr = m;
    @(negedge clk) flag_clr = '0;
    m_fl = m_fl & ~m;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = '0; m_run = 1'b0; m_tx = 1'b0; m_fl = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    ticks(5);
    chk_all("R2 idle ticks");

    delay_val = 8'd5; frame_end_val = 8'd3;
    data_fall();
    chk_all("R3 start on falling edge");
    ticks(3);
    chk_all("R7 frame end flag only");
    ticks(2);
    chk_all("R5 delay reached");
    repeat (20) @(negedge clk);
    chk_all("R4 no advance without carrier");

    clear_flags(3'b010);
    chk_all("R8 flag clear");

    soft_start();
    chk_all("R10 retrigger while running");
    ticks(2);
    chk_all("R10 counting after soft start");

    ticks(int'(STOP) - 2);
    chk_all("R6 terminal reached");
    ticks(4);
    chk_all("R6 ticks after stop ignored");

    clear_flags(3'b111);
    delay_val = STOP;
    data_fall();
    ticks(int'(STOP) - 1);
    chk_all("R9 before terminal");
    ticks(1);
    chk_all("R9 clear wins at terminal");

    for (int it = 0; it < 30; it++) begin
      clear_flags(3'b111);
      delay_val = 8'($urandom_range(1, 120));
      frame_end_val = 8'($urandom_range(1, 120));
      if ($urandom_range(0, 1) == 0) data_fall(); else soft_start();
      ticks($urandom_range(0, 90));
      chk_all("R4 R5 R7 random run");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule